// File: doc/BRIEF.md
# Interrupt Event Pacer

This block thins out a stream of single-cycle event pulses, for example per-channel completion events from a DMA engine, so that a processor sees fewer interrupt pulses. Two cooperating machines decide when a paced pulse is released.

- **Divider.** It counts incoming events against a programmable count threshold.
- **Delay timer.** It measures prescaler ticks against a programmable time threshold, starting from the first event of an interval.

Either machine can end an interval. Per-machine enable bits and counter-clear bits, taken from one 32-bit configuration word, select the behaviour. With both enables off the block is a plain pass-through.

The configuration word may be rewritten at any time. Any change to a used field puts both machines back to idle with cleared counters. The current event count and elapsed time are visible on status outputs.

Top module: `evt_pacer`

## Requirements
- R1: Configuration fields are decoded from `cfg` as follows:
  - bits 27:16: time threshold
  - bits 15:8: count threshold
  - bit 3: time-enable
  - bit 2: count-enable
  - bit 1: time-clear
  - bit 0: count-clear

  Changing any other bit has no effect on outputs or state.
- R2: With both enables 0, an event sampled at clock edge k makes `evt_out` high for exactly the cycle after edge k; the status outputs stay 0.
- R3: With count-enable 1, each event raises `stat_count` by one, starting from 1 after idle. When the incremented count is at least the count threshold, a pulse follows one cycle later; a threshold of 0 behaves like 1. With time-enable 0, that pulse is `evt_out`.
- R4: With count-clear 1, `stat_count` reads 0 in the pulse cycle. With count-clear 0 the count saturates at 255 and holds, so every further event pulses.
- R5: With time-enable 1, an event in idle starts a delay interval. `stat_time` rises by one per `tick` while delaying and saturates at 4095. One cycle after the incremented time is at least the time threshold, `evt_out` pulses for one cycle.
- R6: With both enables 1, a divider result forces the timer to release `evt_out` two cycles after the event that completed the count, unless the timer fired first.
- R7: After a timer pulse, `stat_time` returns to 0 if time-clear is 1 and holds otherwise. An event arriving during any output cycle starts or counts toward the next interval, and a timer pulse is never longer than one cycle.
- R8: A change to a used configuration field idles both machines. On the next cycle `stat_count`, `stat_time` and `evt_out` are 0, and an event in the change cycle is dropped.
- R9: With time-enable 1 and count-enable 0, events never release a pulse by themselves; only the elapsed time does.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 1 | Single-cycle event pulse |
| tick | input | 1 | Prescaler tick strobe |
| cfg | input | 32 | Configuration word |
| evt_out | output | 1 | Paced event pulse |
| stat_count | output | 8 | Current event count |
| stat_time | output | 12 | Current elapsed time in ticks |

## Verification
The status outputs expose both counters on every cycle, so a wrong count or time shows at the ports on the very next clock edge. This holds even in intervals where `evt_out` stays quiet. A wrong machine state shows later: either as a pulse one or two cycles early or late, or as a missing clear right after a configuration change. The bench therefore compares all three outputs on every cycle against its own model, across random event and tick densities and directed thresholds of 0, 1 and the maximum.

// File: rtl/evt_pace_pkg.sv
package evt_pace_pkg;
  parameter int CNT_W  = 8;
  parameter int TIME_W = 12;
  localparam int CFG_W = 32;
  localparam int TLO   = 16;
  localparam int CLO   = 8;

  typedef enum logic [1:0] {PS_IDLE = 2'd0, PS_RUN = 2'd1, PS_FIRE = 2'd2} pace_st_e;

  typedef struct packed {
    logic [TIME_W-1:0] tthr;
    logic [CNT_W-1:0]  cthr;
    logic              tuse;
    logic              cuse;
    logic              tclr;
    logic              cclr;
  } pace_cfg_t;

  function automatic pace_cfg_t cfg_decode(input logic [CFG_W-1:0] w);
    pace_cfg_t c;
    c.tthr = w[TLO +: TIME_W];
    c.cthr = w[CLO +: CNT_W];
    c.tuse = w[3];
    c.cuse = w[2];
    c.tclr = w[1];
    c.cclr = w[0];
    return c;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  function automatic logic [TIME_W-1:0] time_step(input logic [TIME_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction
endpackage

// File: rtl/pace_cfg_reg.sv
module pace_cfg_reg
  import evt_pace_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg,
  output pace_cfg_t        cfg_q,
  output logic             cfg_chg
);
  pace_cfg_t cfg_d;

  assign cfg_d   = cfg_decode(cfg);
  assign cfg_chg = (cfg_d != cfg_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  // R8: after a change cycle the held fields match what was sampled
  p_cfg_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (cfg_q == $past(cfg_d)));
endmodule

// File: rtl/pace_div.sv
module pace_div
  import evt_pace_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             evt,
  input  logic             use_cnt,
  input  logic             clr_cnt,
  input  logic [CNT_W-1:0] thr,
  output logic             fire,
  output logic [CNT_W-1:0] cnt
);
  pace_st_e st, st_n;
  logic [CNT_W-1:0] cnt_n, cnt_inc;
  logic reach;

  assign cnt_inc = cnt_step(cnt);
  assign reach   = (cnt_inc >= thr);
  assign fire    = (st == PS_FIRE);

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    if (evt) begin
      if (!use_cnt) begin
        st_n = PS_FIRE;
      end else if (reach) begin
        st_n  = PS_FIRE;
        cnt_n = clr_cnt ? '0 : cnt_inc;
      end else begin
        st_n  = PS_RUN;
        cnt_n = cnt_inc;
      end
    end else if (st == PS_FIRE) begin
      st_n = (cnt == '0) ? PS_IDLE : PS_RUN;
    end
    if (clr) begin
      st_n  = PS_IDLE;
      cnt_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= PS_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
    end
  end

  // R3: the idle state always holds an empty count
  p_idle_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_IDLE) |-> (cnt == '0));
  // R4: with count-clear set, the output cycle shows a zero count
  p_clear_on_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && clr_cnt) |-> (cnt == '0));
  // R2: a disabled divider never accumulates
  p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_cnt && $past(!use_cnt)) |-> (cnt == '0));
endmodule

// File: rtl/pace_delay.sv
module pace_delay
  import evt_pace_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              evt,
  input  logic              tick,
  input  logic              use_time,
  input  logic              clr_time,
  input  logic [TIME_W-1:0] thr,
  input  logic              div_next,
  output logic              fire,
  output logic [TIME_W-1:0] tm
);
  pace_st_e st, st_n;
  logic [TIME_W-1:0] tm_n, tm_adv;

  assign tm_adv = tick ? time_step(tm) : tm;
  assign fire   = (st == PS_FIRE);

  always_comb begin
    st_n = st;
    tm_n = tm;
    unique case (st)
      PS_IDLE: if (evt && use_time) st_n = PS_RUN;
      PS_RUN: begin
        tm_n = tm_adv;
        if (tm_adv >= thr || div_next) st_n = PS_FIRE;
      end
      PS_FIRE: begin
        if (clr_time) tm_n = '0;
        st_n = evt ? PS_RUN : PS_IDLE;
      end
      default: st_n = PS_IDLE;
    endcase
    if (clr) begin
      st_n = PS_IDLE;
      tm_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= PS_IDLE;
      tm <= '0;
    end else begin
      st <= st_n;
      tm <= tm_n;
    end
  end

  // R7: a timer pulse lasts one cycle
  p_single_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
  // R5: elapsed time moves by at most one step while delaying
  p_time_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_RUN && !clr) |=> (tm == $past(tm) || tm == $past(tm) + 1'b1));
  // R7: time-clear empties the timer after an output cycle
  p_time_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && clr_time && !clr) |=> (tm == '0));
endmodule

// File: rtl/evt_pacer.sv
module evt_pacer
  import evt_pace_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_in,
  input  logic              tick,
  input  logic [31:0]       cfg,
  output logic              evt_out,
  output logic [CNT_W-1:0]  stat_count,
  output logic [TIME_W-1:0] stat_time
);
  pace_cfg_t cfg_q;
  logic cfg_chg, div_fire, dly_fire, div_next;

  pace_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .cfg_q(cfg_q), .cfg_chg(cfg_chg)
  );

  pace_div u_div (
    .clk(clk), .rst_n(rst_n), .clr(cfg_chg), .evt(evt_in),
    .use_cnt(cfg_q.cuse), .clr_cnt(cfg_q.cclr), .thr(cfg_q.cthr),
    .fire(div_fire), .cnt(stat_count)
  );

  assign div_next = cfg_q.cuse && div_fire;

  pace_delay u_dly (
    .clk(clk), .rst_n(rst_n), .clr(cfg_chg), .evt(evt_in), .tick(tick),
    .use_time(cfg_q.tuse), .clr_time(cfg_q.tclr), .thr(cfg_q.tthr),
    .div_next(div_next), .fire(dly_fire), .tm(stat_time)
  );

  assign evt_out = cfg_q.tuse ? dly_fire : div_fire;

  // R8: a configuration change leaves everything idle and empty
  p_cfg_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (!evt_out && stat_count == '0 && stat_time == '0));
  // R2: pass-through releases every accepted event on the next cycle
  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_in && !cfg_chg && !cfg_q.cuse && !cfg_q.tuse) |=> evt_out);
  // R6: a divider result reaches the output within the next cycle
  p_div_forces_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (div_next && cfg_q.tuse && !cfg_chg && !evt_out) |=> evt_out);
endmodule

// File: tb/test_evt_pacer.sv
module test_evt_pacer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_in = 1'b0;
  logic tick = 1'b0;
  logic [31:0] cfg = 32'h0;
  logic evt_out;
  logic [7:0] stat_count;
  logic [11:0] stat_time;

  localparam logic [31:0] MASK = 32'h0FFF_FF0F;

  always #10 clk = ~clk;

  evt_pacer i_evt_pacer (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .tick(tick), .cfg(cfg),
    .evt_out(evt_out), .stat_count(stat_count), .stat_time(stat_time)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  string cur_req = "R10";

  // reference state
  logic [31:0] m_cfg = 32'h0;
  int m_d = 0, m_cnt = 0, m_t = 0, m_time = 0;

  function automatic int sat_add(int v, int lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  function automatic bit exp_out(logic [31:0] c, int d, int t);
    return c[3] ? (t == 2) : (d == 2);
  endfunction

  task automatic model_step(bit e, bit k, logic [31:0] c);
    logic [31:0] cm;
    bit tu, cu, tr, cr, dn;
    int cth, tth, nd, nc, nt, ntime;
    cm = c & MASK;
    if (cm != m_cfg) begin
      m_cfg = cm; m_d = 0; m_cnt = 0; m_t = 0; m_time = 0;
      return;
    end
    tu = m_cfg[3]; cu = m_cfg[2]; tr = m_cfg[1]; cr = m_cfg[0];
    cth = int'(m_cfg[15:8]); tth = int'(m_cfg[27:16]);
    dn = cu && (m_d == 2);
    nd = m_d; nc = m_cnt;
    if (e && !cu) nd = 2;
    else if (e) begin
      nc = sat_add(m_cnt, 255);
      if (nc >= cth) begin nd = 2; if (cr) nc = 0; end
      else nd = 1;
    end else if (m_d == 2) nd = (m_cnt == 0) ? 0 : 1;
    nt = m_t; ntime = m_time;
    if (m_t == 0) begin
      if (e && tu) nt = 1;
    end else if (m_t == 1) begin
      if (k) ntime = sat_add(m_time, 4095);
      if (ntime >= tth || dn) nt = 2;
    end else begin
      if (tr) ntime = 0;
      nt = e ? 1 : 0;
    end
    m_d = nd; m_cnt = nc; m_t = nt; m_time = ntime;
  endtask

  task automatic compare();
    bit eo;
    eo = exp_out(m_cfg, m_d, m_t);
    n_chk++;
    if (evt_out !== eo || stat_count !== m_cnt[7:0] || stat_time !== m_time[11:0]) begin
      n_bad++;
      $display("FAIL %s: out/count/time actual %0b/%0d/%0d expected %0b/%0d/%0d",
               cur_req, evt_out, stat_count, stat_time, eo, m_cnt, m_time);
    end
  endtask

  // one clock: check current outputs, apply inputs, advance model
  task automatic cyc(bit e, bit k, logic [31:0] c);
    @(negedge clk);
    compare();
    evt_in = e; tick = k; cfg = c;
    model_step(e, k, c);
  endtask

  task automatic run_rand(string req, logic [31:0] c, int n, int pe, int pk);
    cur_req = req;
    for (int i = 0; i < n; i++)
      cyc(($urandom % 100) < pe, ($urandom % 100) < pk, c);
  endtask

  function automatic logic [31:0] mk(int tth, int cth, bit tu, bit cu, bit tr, bit cr);
    return {4'h0, tth[11:0], cth[7:0], 4'h0, tu, cu, tr, cr};
  endfunction

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    cur_req = "R10";
    compare();
    rst_n = 1'b1;
    cyc(0, 0, 0);
    // R2 pass-through, dense and sparse
    run_rand("R2", mk(0, 0, 0, 0, 0, 0), 300, 60, 0);
    run_rand("R2", mk(0, 0, 0, 0, 0, 0), 200, 15, 30);
    // R3 divider, thresholds 0, 1, 5
    run_rand("R3", mk(0, 0, 0, 1, 0, 1), 150, 50, 0);
    run_rand("R3", mk(0, 1, 0, 1, 0, 1), 150, 50, 0);
    run_rand("R3", mk(0, 5, 0, 1, 0, 1), 400, 40, 0);
    // R4 count holds without clear; saturation at 255
    run_rand("R4", mk(0, 4, 0, 1, 0, 0), 300, 40, 0);
    cur_req = "R4";
    for (int i = 0; i < 300; i++) cyc(1, 0, mk(0, 255, 0, 1, 0, 0));
    run_rand("R4", mk(0, 255, 0, 1, 0, 1), 700, 80, 0);
    // R5 timer, thresholds 0, 3, 20
    run_rand("R5", mk(0, 0, 1, 0, 1, 0), 200, 20, 50);
    run_rand("R5", mk(3, 0, 1, 0, 1, 0), 400, 20, 50);
    run_rand("R5", mk(20, 0, 1, 0, 1, 0), 1500, 10, 60);
    // R9 timer only: dense events, no ticks => no pulses
    run_rand("R9", mk(2, 0, 1, 0, 1, 0), 200, 90, 0);
    run_rand("R9", mk(6, 1, 1, 0, 1, 1), 800, 70, 20);
    // R6 both machines
    run_rand("R6", mk(50, 3, 1, 1, 1, 1), 1500, 40, 30);
    run_rand("R6", mk(4, 10, 1, 1, 1, 1), 1500, 40, 50);
    // R7 time hold, event during output cycle
    run_rand("R7", mk(5, 0, 1, 0, 0, 0), 600, 30, 50);
    run_rand("R7", mk(2, 2, 1, 1, 0, 0), 600, 60, 60);
    // R5 saturation: threshold 4095 with ticks every cycle
    cur_req = "R5";
    for (int i = 0; i < 4200; i++) cyc(i == 0, 1, mk(4095, 0, 1, 0, 0, 0));
    // R1 unused bits toggle without effect
    cur_req = "R1";
    for (int i = 0; i < 800; i++)
      cyc(($urandom % 100) < 40, ($urandom % 100) < 40,
          mk(7, 3, 1, 1, 1, 1) | ($urandom & ~MASK));
    // R8 config changes mid-interval, with events in the change cycle
    cur_req = "R8";
    for (int j = 0; j < 60; j++) begin
      logic [31:0] c;
      c = mk($urandom % 12, $urandom % 6, $urandom % 2, $urandom % 2,
             $urandom % 2, $urandom % 2);
      cyc(1, 1, c);
      for (int i = 0; i < 40; i++)
        cyc(($urandom % 100) < 40, ($urandom % 100) < 50, c);
    end
    // random mix across all modes
    for (int j = 0; j < 100; j++)
      run_rand("R6", mk($urandom % 16, $urandom % 8, $urandom % 2,
               $urandom % 2, $urandom % 2, $urandom % 2), 100,
               $urandom % 90, $urandom % 90);
    @(negedge clk);
    compare();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule